// File: doc/BRIEF.md
# Power-of-Two Gated Clock Divider Bank

This block derives one or more divided clocks from a crystal reference, each meant to be routed out on a general-purpose pin. Every channel divides by a power of two selected with a 3-bit ratio code, and has an enable bit that starts and stops the output without runt pulses. A small synchronous register port reads and writes each channel's ratio and enable registers. Channels sit in identical register windows placed at a fixed stride above a base address.

The block runs on `clk`, which is taken to run at twice the crystal frequency. One reference period therefore equals two `clk` cycles. This lets a registered output toggle at the full reference rate for the divide-by-1 case. A channel whose divide ratio is `div` holds its output high for `div` clk cycles and then low for `div` clk cycles, so its output frequency is the reference frequency divided by `div`. The intended software sequence is: clear enable, wait for the output to stop, rewrite the ratio, then set enable again.

Top module: `clkdiv_bank`

## Requirements
- R1: With ratio code n in 1..7, an enabled channel produces a square wave with `div = 2^(n-1)` clk cycles high followed by `div` clk cycles low (reference/div in frequency; code 7 gives divide-by-64).
- R2: Ratio code 0 behaves exactly like code 1: one clk cycle high, one clk cycle low (pass-through of the reference rate).
- R3: The ratio register sits at offset 0x43 of a channel window. Bits [2:0] hold the code and read back. Bits [7:3] ignore writes and read as zero.
- R4: The enable register sits at offset 0x46 of a channel window. Bit 7 is the enable and reads back its current value. Bits [6:0] ignore writes and read as zero.
- R5: Channel i occupies the window starting at BASE_ADDR + i*STRIDE (stride 0x100 by default). A write affects only the addressed channel, and a read of any unmapped address returns 0.
- R6: After the clk edge that writes enable to 1, the first rising edge of the output appears within 2*(2+3*div) clk cycles, i.e. 2+3*div reference periods.
- R7: After the clk edge that writes enable to 0, the output is low and stays low within 6*div clk cycles (3*div reference periods).
- R8: Gating is glitch-free. A run starts with a full low phase and stops only at the end of a full low phase, so every high phase lasts exactly `div` clk cycles.
- R9: The ratio is captured when a channel starts. Rewriting the ratio code while the channel runs does not change its output until the channel has been disabled and enabled again, though the new code reads back at once.
- R10: Synchronous active-high reset clears every ratio code and enable bit, drives every output low and clears `rdata`.
- R11: Read data is registered. It appears on `rdata` in the cycle after `sel` is high with `we` low, and `rdata` is 0 after any cycle without a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock at twice the crystal reference rate |
| rst | input | 1 | Synchronous active-high reset |
| sel | input | 1 | Register access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Register byte address |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Registered read data |
| div_clk_o | output | N_INST | Divided clock per channel |

## Verification
The bench builds the bank with three channels, a base address of 0x1000 and the default 0x100 stride. Three channels give a middle window whose neighbours on both sides must stay untouched, and the non-zero base checks that decoding is not tied to address 0. The ratio codes run from 0 up to 7, which drives the phase counter to its widest value of 64 and stretches the enable and disable latency windows to their largest. A behavioural model that keeps its own phase count is compared with every output and with `rdata` on every clock. Directed tests also measure latencies and phase lengths at the ports.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
  localparam int CODE_W   = 3;
  localparam int MAX_CODE = (1 << CODE_W) - 1;
  localparam int DIV_MAX  = 1 << (MAX_CODE - 1);
  localparam int CNT_W    = $clog2(DIV_MAX) + 1;

  typedef logic [CODE_W-1:0] ratio_code_t;
  typedef logic [CNT_W-1:0]  half_len_t;

  // code 0 and code 1 both mean one cycle per phase
  function automatic half_len_t half_from_code(input ratio_code_t code);
    if (code == '0) return CNT_W'(1);
    return CNT_W'(1) << (code - CODE_W'(1));
  endfunction
endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_ratio,
  input  logic              wr_enable,
  input  logic [DATA_W-1:0] wdata,
  output ratio_code_t       ratio_q,
  output logic              enable_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      ratio_q  <= '0;
      enable_q <= 1'b0;
    end else begin
      if (wr_ratio)  ratio_q  <= wdata[CODE_W-1:0];
      if (wr_enable) enable_q <= wdata[DATA_W-1];
    end
  end
endmodule

// File: rtl/clkdiv_sync.sv
module clkdiv_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/clkdiv_gen.sv
module clkdiv_gen
  import clkdiv_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        enable_s,
  input  ratio_code_t ratio,
  output logic        div_clk,
  output logic        running,
  output half_len_t   half_len
);
  half_len_t phase_cnt;
  logic      phase_end;

  assign phase_end = (phase_cnt == half_len - CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      div_clk   <= 1'b0;
      phase_cnt <= '0;
      half_len  <= CNT_W'(1);
    end else if (!running) begin
      div_clk   <= 1'b0;
      phase_cnt <= '0;
      if (enable_s) begin
        running  <= 1'b1;
        half_len <= half_from_code(ratio);
      end
    end else if (phase_end) begin
      phase_cnt <= '0;
      if (!div_clk && !enable_s) running <= 1'b0;
      else                       div_clk <= ~div_clk;
    end else begin
      phase_cnt <= phase_cnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/clkdiv_bank.sv
module clkdiv_bank
  import clkdiv_pkg::*;
#(
  parameter int N_INST    = 4,
  parameter int ADDR_W    = 16,
  parameter int DATA_W    = 8,
  parameter int BASE_ADDR = 0,
  parameter int STRIDE    = 256,
  parameter int RATIO_OFS = 'h43,
  parameter int EN_OFS    = 'h46,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [N_INST-1:0] div_clk_o
);
  logic [N_INST-1:0]             hit_ratio, hit_en, enable_q, enable_s, run_w;
  ratio_code_t [N_INST-1:0]      ratio_q;
  half_len_t   [N_INST-1:0]      half_w;
  logic [N_INST-1:0][DATA_W-1:0] rd_part;
  logic [DATA_W-1:0]             rd_mux;

  for (genvar i = 0; i < N_INST; i++) begin : g_ch
    localparam logic [ADDR_W-1:0] WIN = ADDR_W'(BASE_ADDR + i * STRIDE);

    assign hit_ratio[i] = sel && (addr == WIN + ADDR_W'(RATIO_OFS));
    assign hit_en[i]    = sel && (addr == WIN + ADDR_W'(EN_OFS));

    clkdiv_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst       (rst),
      .wr_ratio  (hit_ratio[i] && we),
      .wr_enable (hit_en[i] && we),
      .wdata     (wdata),
      .ratio_q   (ratio_q[i]),
      .enable_q  (enable_q[i])
    );

    clkdiv_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk (clk),
      .rst (rst),
      .d   (enable_q[i]),
      .q   (enable_s[i])
    );

    clkdiv_gen u_gen (
      .clk      (clk),
      .rst      (rst),
      .enable_s (enable_s[i]),
      .ratio    (ratio_q[i]),
      .div_clk  (div_clk_o[i]),
      .running  (run_w[i]),
      .half_len (half_w[i])
    );

    always_comb begin
      rd_part[i] = '0;
      if (hit_ratio[i]) rd_part[i][CODE_W-1:0] = ratio_q[i];
      if (hit_en[i])    rd_part[i][DATA_W-1]   = enable_q[i];
    end
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < N_INST; i++) rd_mux = rd_mux | rd_part[i];
  end

  always_ff @(posedge clk) begin
    if (rst)             rdata <= '0;
    else if (sel && !we) rdata <= rd_mux;
    else                 rdata <= '0;
  end
endmodule

// File: rtl/clkdiv_bank_chk.sv
module clkdiv_bank_chk
  import clkdiv_pkg::*;
#(
  parameter int N_INST = 4,
  parameter int DATA_W = 8
) (
  input logic                   clk,
  input logic                   rst,
  input logic [DATA_W-1:0]      rdata,
  input logic [N_INST-1:0]      div_clk_o,
  input logic [N_INST-1:0]      run_w,
  input half_len_t [N_INST-1:0] half_w
);
  // R10: reset leaves outputs low and read data clear
  assert_reset_quiet_R10: assert property (@(posedge clk)
    rst |=> (div_clk_o == '0 && rdata == '0));

  // R3 and R4: the middle bits belong to no field and always read zero
  assert_unused_zero_R4: assert property (@(posedge clk) disable iff (rst)
    rdata[DATA_W-2:CODE_W] == '0);

  for (genvar i = 0; i < N_INST; i++) begin : g_c
    half_len_t hi_cnt;
    always_ff @(posedge clk) begin
      if (rst)               hi_cnt <= '0;
      else if (div_clk_o[i]) hi_cnt <= hi_cnt + CNT_W'(1);
      else                   hi_cnt <= '0;
    end

    // R8: every high phase spans the full half period
    assert_full_high_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(div_clk_o[i]) |-> (hi_cnt == half_w[i]));

    // R8: a run ends only after a low phase
    assert_stop_low_R8: assert property (@(posedge clk) disable iff (rst)
      $fell(run_w[i]) |-> $past(!div_clk_o[i]));

    // R9: ratio in use is frozen while running
    assert_ratio_frozen_R9: assert property (@(posedge clk) disable iff (rst)
      (run_w[i] && $past(run_w[i])) |-> $stable(half_w[i]));
  end
endmodule

bind clkdiv_bank clkdiv_bank_chk #(.N_INST(N_INST), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .rdata     (rdata),
  .div_clk_o (div_clk_o),
  .run_w     (run_w),
  .half_w    (half_w)
);

// File: tb/clkdiv_bank_tb.sv
module clkdiv_bank_tb;
  localparam int N    = 3;
  localparam int AW   = 16;
  localparam int BASE = 'h1000;
  localparam int STR  = 'h100;
  localparam int ROFS = 'h43;
  localparam int EOFS = 'h46;

  logic          clk = 0;
  logic          rst = 1;
  logic          sel = 0;
  logic          we = 0;
  logic [AW-1:0] addr = '0;
  logic [7:0]    wdata = '0;
  logic [7:0]    rdata;
  logic [N-1:0]  div_clk_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  clkdiv_bank #(.N_INST(N), .ADDR_W(AW), .DATA_W(8), .BASE_ADDR(BASE),
                .STRIDE(STR)) u_dut (
    .clk(clk), .rst(rst), .sel(sel), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .div_clk_o(div_clk_o));

  always #4 clk = ~clk;

  // behavioural reference model
  int m_code[N], m_en[N], m_s1[N], m_s2[N], m_run[N], m_k[N], m_div[N];
  int m_rdata;

  function automatic int ch_addr(int ch, int ofs);
    return BASE + ch * STR + ofs;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_code[i] = 0; m_en[i] = 0; m_s1[i] = 0; m_s2[i] = 0;
        m_run[i] = 0; m_k[i] = 0; m_div[i] = 1;
      end
      m_rdata = 0;
    end else begin
      int rd;
      rd = 0;
      for (int i = 0; i < N; i++) begin
        if (int'(addr) == ch_addr(i, ROFS)) rd = m_code[i];
        if (int'(addr) == ch_addr(i, EOFS)) rd = m_en[i] * 128;
      end
      m_rdata = (sel && !we) ? rd : 0;
      for (int i = 0; i < N; i++) begin
        int old_en;
        old_en = m_en[i];
        if (!m_run[i]) begin
          if (m_s2[i] != 0) begin
            m_run[i] = 1; m_k[i] = 0;
            m_div[i] = (m_code[i] == 0) ? 1 : (1 << (m_code[i] - 1));
          end
        end else if ((m_k[i] % (2 * m_div[i])) == m_div[i] - 1 && m_s2[i] == 0) begin
          m_run[i] = 0;
        end else begin
          m_k[i]++;
        end
        m_s2[i] = m_s1[i];
        m_s1[i] = old_en;
        if (sel && we && int'(addr) == ch_addr(i, ROFS)) m_code[i] = wdata & 7;
        if (sel && we && int'(addr) == ch_addr(i, EOFS)) m_en[i] = wdata[7];
      end
    end
  end

  function automatic int m_out(int i);
    return m_run[i] ? ((m_k[i] / m_div[i]) % 2) : 0;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!rst && !done) begin
      for (int i = 0; i < N; i++)
        check("R1/R8 model output", int'(div_clk_o[i]), m_out(i));
      check("R11 model rdata", int'(rdata), m_rdata);
    end
  end

  task automatic wr(int a, int d);
    sel = 1; we = 1; addr = AW'(a); wdata = 8'(d);
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd_chk(int a, int exp, string tag);
    sel = 1; we = 0; addr = AW'(a);
    @(negedge clk);
    sel = 0;
    check(tag, int'(rdata), exp);
  endtask

  task automatic wait_level(int ch, bit lvl, output int n);
    n = 0;
    while (div_clk_o[ch] != lvl && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  // enable, measure latency and both phase lengths, then disable
  task automatic run_code(int ch, int code, string tag);
    int div, n, hi, lo;
    div = (code == 0) ? 1 : (1 << (code - 1));
    wr(ch_addr(ch, ROFS), code);
    wr(ch_addr(ch, EOFS), 'h80);
    wait_level(ch, 1, n);
    check("R6 enable latency bound", int'(n <= 4 + 6 * div), 1);
    wait_level(ch, 0, hi);
    wait_level(ch, 1, lo);
    check({tag, " high phase"}, hi, div);
    check({tag, " low phase"}, lo, div);
    wr(ch_addr(ch, EOFS), 0);
    for (int c = 1; c < 6 * div; c++) @(negedge clk);
    for (int c = 0; c < 2 * div + 2; c++) begin
      check("R7 stopped after disable", int'(div_clk_o[ch]), 0);
      @(negedge clk);
    end
  endtask

  initial begin
    int n, hi;
    repeat (3) @(negedge clk);
    rst = 0;
    check("R10 outputs low after reset", int'(div_clk_o), 0);
    check("R10 rdata clear after reset", int'(rdata), 0);
    rd_chk(ch_addr(0, ROFS), 0, "R10 ratio code reset");
    rd_chk(ch_addr(0, EOFS), 0, "R10 enable reset");

    wr(ch_addr(0, ROFS), 'hF8);
    rd_chk(ch_addr(0, ROFS), 0, "R3 upper ratio bits ignored");
    wr(ch_addr(0, ROFS), 'hFF);
    rd_chk(ch_addr(0, ROFS), 7, "R3 ratio readback");
    wr(ch_addr(1, EOFS), 'h7F);
    rd_chk(ch_addr(1, EOFS), 0, "R4 low enable bits ignored");
    rd_chk(ch_addr(1, ROFS), 0, "R5 neighbour ratio untouched");
    rd_chk(ch_addr(0, 'h44), 0, "R5 unmapped read");
    rd_chk(BASE + N * STR + ROFS, 0, "R5 beyond last window");
    @(negedge clk);
    check("R11 rdata zero without read", int'(rdata), 0);

    run_code(0, 0, "R2 code0");
    run_code(0, 1, "R2 code1");
    run_code(0, 2, "R1 code2");
    run_code(0, 3, "R1 code3");
    run_code(0, 7, "R1 code7");

    // middle channel alone
    wr(ch_addr(1, ROFS), 2);
    wr(ch_addr(1, EOFS), 'h80);
    rd_chk(ch_addr(1, EOFS), 'h80, "R4 enable readback");
    rd_chk(ch_addr(0, EOFS), 0, "R5 channel 0 enable untouched");
    wait_level(1, 1, n);
    check("R5 other channels idle", int'(div_clk_o[0] | div_clk_o[2]), 0);

    // ratio rewrite while running
    wr(ch_addr(1, ROFS), 4);
    rd_chk(ch_addr(1, ROFS), 4, "R9 new code reads back");
    wait_level(1, 0, n);
    wait_level(1, 1, n);
    wait_level(1, 0, hi);
    check("R9 running ratio unchanged", hi, 2);
    wr(ch_addr(1, EOFS), 0);
    repeat (20) @(negedge clk);
    wr(ch_addr(1, EOFS), 'h80);
    wait_level(1, 1, n);
    wait_level(1, 0, hi);
    check("R9 new ratio after restart", hi, 8);
    wr(ch_addr(1, EOFS), 0);
    repeat (30) @(negedge clk);
    check("R7 channel 1 stopped", int'(div_clk_o), 0);

    // two channels concurrently, model compared each clock
    wr(ch_addr(2, ROFS), 1);
    wr(ch_addr(0, ROFS), 5);
    wr(ch_addr(2, EOFS), 'h80);
    wr(ch_addr(0, EOFS), 'h80);
    repeat (100) @(negedge clk);
    wr(ch_addr(2, EOFS), 0);
    wr(ch_addr(0, EOFS), 0);
    repeat (120) @(negedge clk);
    check("R8 all stopped", int'(div_clk_o), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule